// File: doc/BRIEF.md
# UART status flag and interrupt unit

This block keeps the status state of a UART and turns it into interrupt requests. It holds five flags: transmit buffer empty, receive data full, and three receive error flags for framing, overrun and parity. It also holds two interrupt enables. The UART core sends it one-cycle event strobes. These mark a CPU write of the transmit data register, the move of the buffered byte into the transmit shift register, a completed receive, a CPU read of the receive data register, and a framing or parity error. The block creates the overrun event itself.

The CPU writes the two enables through the status byte. It clears all three error flags at once by writing 0 to an error-clear bit in a separate control register. The block drives two level interrupt requests, a receive-data-valid indication and an 8-bit readable status byte. The block carries no data stream, so all of its pins are plain control and status pins with no handshake.

Top module: `uart_stat_irq`

## Requirements
- R1: After reset, status_o reads 8'h08: transmit buffer empty is 1, and every other flag and both enables are 0. tx_irq_o, rx_irq_o and rx_data_valid_o are 0.
- R2: On a cycle with en_wr_i high, en_wdata_i[0] loads the transmit enable and en_wdata_i[1] loads the receive enable. These appear as status bits 0 and 1. en_wdata_i[7:2] has no effect: status bit 2 always reads 0, and bits 7:3 do not change.
- R3: tx_load_i clears transmit buffer empty (status bit 3) to 0.
- R4: tx_shift_i sets status bit 3 to 1. When tx_shift_i and tx_load_i are high together, the set wins.
- R5: tx_irq_o is the transmit enable ANDed with status bit 3.
- R6: rx_done_i sets receive data full (status bit 4), and rx_read_i clears it. When both are high together, the set wins.
- R7: frame_err_i sets status bit 5, and par_err_i sets status bit 7.
- R8: The block raises the overrun flag (status bit 6) when rx_done_i is high while bit 4 is already 1 and rx_read_i is low.
- R9: Status bits 5, 6 and 7 clear only on a cycle with errclr_wr_i high and errclr_wdata_i low. Writing 1 to the error-clear bit has no effect, and neither does rx_read_i. When an error event and the clear arrive together, the error event wins.
- R10: rx_irq_o is the receive enable ANDed with the OR of status bits 4 to 7.
- R11: rx_data_valid_o is 1 exactly when status bit 4 is 1 and bits 5 to 7 are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_load_i | input | 1 | CPU wrote the transmit data register |
| tx_shift_i | input | 1 | Buffered byte moved to the transmit shift register |
| rx_done_i | input | 1 | Received byte loaded into the receive data register |
| rx_read_i | input | 1 | CPU read the receive data register |
| frame_err_i | input | 1 | Framing error on the current receive |
| par_err_i | input | 1 | Parity error on the current receive |
| en_wr_i | input | 1 | Write strobe for the status byte (enables only) |
| en_wdata_i | input | 8 | Status byte write data |
| errclr_wr_i | input | 1 | Write strobe for the control register error-clear bit |
| errclr_wdata_i | input | 1 | Error-clear bit value; 0 clears the error flags |
| tx_irq_o | output | 1 | Transmit interrupt request (level) |
| rx_irq_o | output | 1 | Receive interrupt request (level) |
| rx_data_valid_o | output | 1 | Receive data register holds valid data |
| status_o | output | 8 | Readable status byte |

## Verification
Every flag and enable is a register. It takes its new value on the rising edge that samples the strobe or write. Each output is combinational from those registers, so every result is due exactly one edge after its stimulus. The bench drives each stimulus on a falling edge and removes it on the next falling edge, then checks. That point lies half a period after the single edge that acts on the stimulus and before any further edge. Combined events, such as a set and a clear in the same cycle or an overrun, use the same one-edge window, so no check depends on a multi-cycle wait.

// File: rtl/uart_stat_pkg.sv
package uart_stat_pkg;
  localparam int STAT_W  = 8;
  localparam int ERR_CNT = 3;

  localparam int ST_TXEN  = 0;
  localparam int ST_RXEN  = 1;
  localparam int ST_RSVD  = 2;
  localparam int ST_TBE   = 3;
  localparam int ST_RDF   = 4;
  localparam int ST_ERR_LO = 5;

  typedef enum logic [1:0] {
    ERR_FRAME = 2'd0,
    ERR_OVRN  = 2'd1,
    ERR_PAR   = 2'd2
  } err_idx_e;
endpackage

// File: rtl/usi_flag.sv
module usi_flag #(
  parameter bit RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q_o <= RST_VAL;
    else if (set_i) q_o <= 1'b1;
    else if (clr_i) q_o <= 1'b0;
  end
endmodule

// File: rtl/usi_err_bank.sv
module usi_err_bank #(
  parameter int NUM_ERR = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_ERR-1:0] set_i,
  input  logic               clr_i,
  output logic [NUM_ERR-1:0] err_o
);
  for (genvar g = 0; g < NUM_ERR; g++) begin : g_err
    usi_flag #(.RST_VAL(1'b0)) u_flag (
      .clk  (clk),
      .rst_n(rst_n),
      .set_i(set_i[g]),
      .clr_i(clr_i),
      .q_o  (err_o[g])
    );
  end
endmodule

// File: rtl/usi_irq_comb.sv
module usi_irq_comb #(
  parameter int NUM_ERR = 3
) (
  input  logic               tx_en_i,
  input  logic               rx_en_i,
  input  logic               tbe_i,
  input  logic               rdf_i,
  input  logic [NUM_ERR-1:0] err_i,
  output logic               tx_irq_o,
  output logic               rx_irq_o,
  output logic               valid_o
);
  logic any_err;

  always_comb begin
    any_err  = |err_i;
    tx_irq_o = tx_en_i & tbe_i;
    rx_irq_o = rx_en_i & (rdf_i | any_err);
    valid_o  = rdf_i & ~any_err;
  end
endmodule

// File: rtl/uart_stat_irq.sv
module uart_stat_irq
  import uart_stat_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_load_i,
  input  logic              tx_shift_i,
  input  logic              rx_done_i,
  input  logic              rx_read_i,
  input  logic              frame_err_i,
  input  logic              par_err_i,
  input  logic              en_wr_i,
  input  logic [STAT_W-1:0] en_wdata_i,
  input  logic              errclr_wr_i,
  input  logic              errclr_wdata_i,
  output logic              tx_irq_o,
  output logic              rx_irq_o,
  output logic              rx_data_valid_o,
  output logic [STAT_W-1:0] status_o
);
  logic               tx_en_q, rx_en_q;
  logic               tbe, rdf;
  logic [ERR_CNT-1:0] err_set, err_q;
  logic               err_clr;
  logic               ovrn_evt;
  logic               unused_wbits;

  assign unused_wbits = ^en_wdata_i[STAT_W-1:ST_RSVD];

  // Interrupt enables, written through the status byte.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_en_q <= 1'b0;
      rx_en_q <= 1'b0;
    end else if (en_wr_i) begin
      tx_en_q <= en_wdata_i[ST_TXEN];
      rx_en_q <= en_wdata_i[ST_RXEN];
    end
  end

  usi_flag #(.RST_VAL(1'b1)) u_tbe (
    .clk  (clk),
    .rst_n(rst_n),
    .set_i(tx_shift_i),
    .clr_i(tx_load_i),
    .q_o  (tbe)
  );

  usi_flag #(.RST_VAL(1'b0)) u_rdf (
    .clk  (clk),
    .rst_n(rst_n),
    .set_i(rx_done_i),
    .clr_i(rx_read_i),
    .q_o  (rdf)
  );

  // New byte lands while the previous one is still unread.
  assign ovrn_evt = rx_done_i & rdf & ~rx_read_i;

  always_comb begin
    err_set            = '0;
    err_set[ERR_FRAME] = frame_err_i;
    err_set[ERR_OVRN]  = ovrn_evt;
    err_set[ERR_PAR]   = par_err_i;
    err_clr            = errclr_wr_i & ~errclr_wdata_i;
  end

  usi_err_bank #(.NUM_ERR(ERR_CNT)) u_errs (
    .clk  (clk),
    .rst_n(rst_n),
    .set_i(err_set),
    .clr_i(err_clr),
    .err_o(err_q)
  );

  usi_irq_comb #(.NUM_ERR(ERR_CNT)) u_irq (
    .tx_en_i (tx_en_q),
    .rx_en_i (rx_en_q),
    .tbe_i   (tbe),
    .rdf_i   (rdf),
    .err_i   (err_q),
    .tx_irq_o(tx_irq_o),
    .rx_irq_o(rx_irq_o),
    .valid_o (rx_data_valid_o)
  );

  always_comb begin
    status_o                            = '0;
    status_o[ST_TXEN]                   = tx_en_q;
    status_o[ST_RXEN]                   = rx_en_q;
    status_o[ST_TBE]                    = tbe;
    status_o[ST_RDF]                    = rdf;
    status_o[ST_ERR_LO+ERR_CNT-1:ST_ERR_LO] = err_q;
  end
endmodule

// File: rtl/uart_stat_irq_chk.sv
module uart_stat_irq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tx_load_i,
  input logic       tx_shift_i,
  input logic       rx_done_i,
  input logic       rx_read_i,
  input logic       frame_err_i,
  input logic       par_err_i,
  input logic       errclr_wr_i,
  input logic       errclr_wdata_i,
  input logic       tx_irq_o,
  input logic       rx_irq_o,
  input logic       rx_data_valid_o,
  input logic [7:0] status_o
);
  a_r2_rsvd_zero: assert property (@(posedge clk) disable iff (!rst_n)
    status_o[2] == 1'b0);

  a_r3_tbe_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_load_i && !tx_shift_i) |=> !status_o[3]);

  a_r4_tbe_set: assert property (@(posedge clk) disable iff (!rst_n)
    tx_shift_i |=> status_o[3]);

  a_r5_txirq_off: assert property (@(posedge clk) disable iff (!rst_n)
    !status_o[0] |-> !tx_irq_o);

  a_r6_rdf_set: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done_i |=> status_o[4]);

  a_r7_fe_set: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err_i |=> status_o[5]);

  a_r7_pe_set: assert property (@(posedge clk) disable iff (!rst_n)
    par_err_i |=> status_o[7]);

  a_r8_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done_i && status_o[4] && !rx_read_i) |=> status_o[6]);

  a_r9_err_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(errclr_wr_i && !errclr_wdata_i) |=>
      ((status_o[7:5] & $past(status_o[7:5])) == $past(status_o[7:5])));

  a_r10_rxirq_off: assert property (@(posedge clk) disable iff (!rst_n)
    !status_o[1] |-> !rx_irq_o);

  a_r11_err_invalid: assert property (@(posedge clk) disable iff (!rst_n)
    (|status_o[7:5]) |-> !rx_data_valid_o);
endmodule

bind uart_stat_irq uart_stat_irq_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .tx_load_i      (tx_load_i),
  .tx_shift_i     (tx_shift_i),
  .rx_done_i      (rx_done_i),
  .rx_read_i      (rx_read_i),
  .frame_err_i    (frame_err_i),
  .par_err_i      (par_err_i),
  .errclr_wr_i    (errclr_wr_i),
  .errclr_wdata_i (errclr_wdata_i),
  .tx_irq_o       (tx_irq_o),
  .rx_irq_o       (rx_irq_o),
  .rx_data_valid_o(rx_data_valid_o),
  .status_o       (status_o)
);

// File: tb/sim_uart_stat_irq.sv
module sim_uart_stat_irq;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tx_load_i = 0, tx_shift_i = 0, rx_done_i = 0, rx_read_i = 0;
  logic       frame_err_i = 0, par_err_i = 0, en_wr_i = 0;
  logic [7:0] en_wdata_i = '0;
  logic       errclr_wr_i = 0, errclr_wdata_i = 1;
  logic       tx_irq_o, rx_irq_o, rx_data_valid_o;
  logic [7:0] status_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_stat_irq u0 (
    .clk(clk), .rst_n(rst_n),
    .tx_load_i(tx_load_i), .tx_shift_i(tx_shift_i),
    .rx_done_i(rx_done_i), .rx_read_i(rx_read_i),
    .frame_err_i(frame_err_i), .par_err_i(par_err_i),
    .en_wr_i(en_wr_i), .en_wdata_i(en_wdata_i),
    .errclr_wr_i(errclr_wr_i), .errclr_wdata_i(errclr_wdata_i),
    .tx_irq_o(tx_irq_o), .rx_irq_o(rx_irq_o),
    .rx_data_valid_o(rx_data_valid_o), .status_o(status_o)
  );

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Stimulus is already set after a falling edge; one rising edge acts on it.
  task automatic step();
    @(negedge clk);
    tx_load_i = 0; tx_shift_i = 0; rx_done_i = 0; rx_read_i = 0;
    frame_err_i = 0; par_err_i = 0; en_wr_i = 0; en_wdata_i = '0;
    errclr_wr_i = 0; errclr_wdata_i = 1;
  endtask

  task automatic wr_en(logic [7:0] v);
    @(negedge clk); en_wr_i = 1; en_wdata_i = v; step();
  endtask

  task automatic clr_errs();
    @(negedge clk); errclr_wr_i = 1; errclr_wdata_i = 0; step();
  endtask

  task automatic t_reset();
    chk("R1 status", status_o, 8'h08);
    chk("R1 tx_irq", {7'd0, tx_irq_o}, 8'd0);
    chk("R1 rx_irq", {7'd0, rx_irq_o}, 8'd0);
    chk("R1 valid", {7'd0, rx_data_valid_o}, 8'd0);
  endtask

  task automatic t_enables();
    wr_en(8'hFF);
    chk("R2 write all ones", status_o, 8'h0B);
    chk("R5 tx_irq enabled with empty buffer", {7'd0, tx_irq_o}, 8'd1);
    wr_en(8'h04);
    chk("R2 reserved bit write", status_o, 8'h08);
    chk("R5 tx_irq disabled", {7'd0, tx_irq_o}, 8'd0);
  endtask

  task automatic t_tx();
    wr_en(8'h01);
    @(negedge clk); tx_load_i = 1; step();
    chk("R3 load clears empty", status_o, 8'h01);
    chk("R5 tx_irq drops", {7'd0, tx_irq_o}, 8'd0);
    @(negedge clk); tx_shift_i = 1; step();
    chk("R4 shift sets empty", status_o, 8'h09);
    chk("R5 tx_irq rises", {7'd0, tx_irq_o}, 8'd1);
    @(negedge clk); tx_load_i = 1; step();
    @(negedge clk); tx_load_i = 1; tx_shift_i = 1; step();
    chk("R4 set wins over load", status_o, 8'h09);
    wr_en(8'h00);
  endtask

  task automatic t_rx();
    wr_en(8'h02);
    chk("R10 no flags no rx_irq", {7'd0, rx_irq_o}, 8'd0);
    @(negedge clk); rx_done_i = 1; step();
    chk("R6 rx sets full", status_o, 8'h1A);
    chk("R10 rx_irq on data", {7'd0, rx_irq_o}, 8'd1);
    chk("R11 valid with data", {7'd0, rx_data_valid_o}, 8'd1);
    @(negedge clk); rx_read_i = 1; step();
    chk("R6 read clears full", status_o, 8'h0A);
    chk("R10 rx_irq drops", {7'd0, rx_irq_o}, 8'd0);
    @(negedge clk); rx_done_i = 1; rx_read_i = 1; step();
    chk("R6 set wins over read", status_o, 8'h1A);
    @(negedge clk); rx_done_i = 1; rx_read_i = 1; step();
    chk("R8 read same cycle no overrun", status_o, 8'h1A);
    @(negedge clk); rx_read_i = 1; step();
  endtask

  task automatic t_overrun();
    @(negedge clk); rx_done_i = 1; step();
    @(negedge clk); rx_done_i = 1; step();
    chk("R8 overrun flagged", status_o, 8'h5A);
    chk("R11 overrun invalidates", {7'd0, rx_data_valid_o}, 8'd0);
    @(negedge clk); rx_read_i = 1; step();
    chk("R9 read keeps overrun", status_o, 8'h4A);
    chk("R10 rx_irq from error", {7'd0, rx_irq_o}, 8'd1);
    clr_errs();
    chk("R9 clear removes overrun", status_o, 8'h0A);
    chk("R10 rx_irq gone after clear", {7'd0, rx_irq_o}, 8'd0);
  endtask

  task automatic t_errs();
    @(negedge clk); rx_done_i = 1; frame_err_i = 1; step();
    chk("R7 framing set", status_o, 8'h3A);
    chk("R11 framing invalidates", {7'd0, rx_data_valid_o}, 8'd0);
    @(negedge clk); rx_read_i = 1; errclr_wr_i = 1; errclr_wdata_i = 1; step();
    chk("R9 writing one keeps error", status_o, 8'h2A);
    @(negedge clk); par_err_i = 1; step();
    chk("R7 parity set", status_o, 8'hAA);
    @(negedge clk); frame_err_i = 1; errclr_wr_i = 1; errclr_wdata_i = 0; step();
    chk("R9 set wins over clear", status_o, 8'h2A);
    clr_errs();
    chk("R9 final clear", status_o, 8'h0A);
    wr_en(8'h00);
    @(negedge clk); par_err_i = 1; step();
    chk("R10 disabled masks rx_irq", {7'd0, rx_irq_o}, 8'd0);
    clr_errs();
    chk("R9 clear with enables off", status_o, 8'h08);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_enables();
    t_tx();
    t_rx();
    t_overrun();
    t_errs();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule